// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM with Zero Bus Turnaround

This block is a single-port static memory with one shared bidirectional data bus. Reads and writes can follow each other in any order on consecutive clocks, and every clock can move one data word. Address and control are registered on the rising edge. Read data leaves the array in the same cycle as its registered address, with no output register stage. Write data follows its address by one active clock.

While a write waits for its data, its address and byte enables are held in a pending register. The written word is not stored in the array at once. It stays in a one-entry write buffer until the next write's data arrives and displaces it. A read that hits the buffered address gets the buffered bytes merged over the array word.

A short burst engine can advance the address inside a four-word group, in linear or interleaved order. A clock enable can freeze the whole block. The array depth is a parameter: `ADDR_W` = 18 gives the full 256K words, and the default is smaller for simulation.

Top module: `flowthru_sram`

## Requirements
- R1: After reset the block does not drive `dq` until a read has been loaded.
- R2: A read loaded at edge n (`load_new`=1, `wr_en`=0, chip selects active) drives the stored word on `dq` from edge n until edge n+1, provided `out_en`=1.
- R3: A write loaded at edge n takes its data from `dq` at the next active edge. `byte_wr[0]` gates bits 8:0 and `byte_wr[1]` gates bits 17:9. The byte selects are sampled at the edge that registers the address.
- R4: An access starts only when `chip_sel_n0`=0, `chip_sel1`=1 and `chip_sel_n2`=0 at a load edge. In any other case the cycle is a deselect: nothing is driven and nothing is written.
- R5: An edge with `clk_en`=0 is ignored. The bus state and any read data are held, and a write data phase stretches until the next active edge.
- R6: The block never drives `dq` during a write data phase, whatever the value of `out_en`. Taking `out_en` low releases the bus at once, without waiting for a clock.
- R7: Reads and writes may alternate on every clock. A read of a word whose write has not yet reached the array returns the new bytes, merged per byte select.
- R8: With `load_new`=0 the previous access type continues at the next burst address. The bits above bit 1 stay fixed. In linear order (`seq_mode`=0 at the load edge), burst step k uses offset (start+k) mod 4.
- R9: In interleaved order (`seq_mode`=1 at the load edge), burst step k uses offset start XOR k.
- R10: During advance cycles `wr_en`, the chip selects and `seq_mode` are ignored. An advance after a deselect stays deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en | input | 1 | Clock enable; 0 ignores the edge |
| addr | input | ADDR_W | Word address, sampled on load edges |
| load_new | input | 1 | 1 = load a new address, 0 = advance the burst |
| wr_en | input | 1 | 1 = write, 0 = read (load edges only) |
| byte_wr | input | 2 | Per-byte write selects for the data phase |
| chip_sel_n0 | input | 1 | Chip select, active low |
| chip_sel1 | input | 1 | Chip select, active high |
| chip_sel_n2 | input | 1 | Chip select, active low |
| out_en | input | 1 | Asynchronous output-driver enable |
| seq_mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| dq | inout | 18 | Shared data bus |

## Verification
The hardest case is a read that hits a word still held in the write buffer, above all after a partial-byte write, while the array still holds the stale copy. The stimulus reaches it with directed write-then-read pairs to the same address using single-byte selects. Random traffic is confined to a 32-word window, so reads often land on the word just written, including during bursts and stalls. A later write to a different address pushes the buffered word into the array, and rereading it then checks the array path.

// File: rtl/fts_pkg.sv
`timescale 1ns/1ps
package fts_pkg;
  localparam int OFS_W = 2;
  typedef logic [OFS_W-1:0] ofs_t;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_INTERLEAVE = 1'b1} burst_ord_e;

  // Offset of burst step 'step' starting from 'start'.
  function automatic ofs_t next_ofs(input ofs_t start, input ofs_t step, input burst_ord_e ord);
    if (ord == ORD_INTERLEAVE) return start ^ step;
    return start + step;
  endfunction
endpackage

// File: rtl/fts_rst_sync.sv
`timescale 1ns/1ps
module fts_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sh_q[STAGES-1];
endmodule

// File: rtl/fts_addr_seq.sv
`timescale 1ns/1ps
module fts_addr_seq
  import fts_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int NBYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              load_new,
  input  logic              wr_en,
  input  logic              sel_ok,
  input  logic              seq_mode,
  input  logic [NBYTES-1:0] byte_wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              cur_valid,
  output logic              cur_write,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [NBYTES-1:0] cur_be
);
  logic              valid_q, valid_d, write_q, write_d;
  logic [ADDR_W-1:0] addr_q, addr_d, base_q, base_d;
  ofs_t              cnt_q, cnt_d;
  burst_ord_e        ord_q, ord_d;
  logic [NBYTES-1:0] be_q, be_d;

  always_comb begin
    valid_d = valid_q;
    write_d = write_q;
    addr_d  = addr_q;
    base_d  = base_q;
    cnt_d   = cnt_q;
    ord_d   = ord_q;
    be_d    = byte_wr;
    if (load_new) begin
      valid_d = sel_ok;
      write_d = wr_en;
      addr_d  = addr;
      base_d  = addr;
      cnt_d   = '0;
      ord_d   = seq_mode ? ORD_INTERLEAVE : ORD_LINEAR;
    end else begin
      cnt_d  = cnt_q + 2'd1;
      addr_d = {base_q[ADDR_W-1:OFS_W], next_ofs(base_q[OFS_W-1:0], cnt_d, ord_q)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      write_q <= 1'b0;
      addr_q  <= '0;
      base_q  <= '0;
      cnt_q   <= '0;
      ord_q   <= ORD_LINEAR;
      be_q    <= '0;
    end else if (clk_en) begin
      valid_q <= valid_d;
      write_q <= write_d;
      addr_q  <= addr_d;
      base_q  <= base_d;
      cnt_q   <= cnt_d;
      ord_q   <= ord_d;
      be_q    <= be_d;
    end
  end

  assign cur_valid = valid_q;
  assign cur_write = write_q;
  assign cur_addr  = addr_q;
  assign cur_be    = be_q;
endmodule

// File: rtl/fts_wr_buf.sv
`timescale 1ns/1ps
module fts_wr_buf #(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 2,
  localparam int DATA_W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              cap,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [NBYTES-1:0] cap_be,
  input  logic [DATA_W-1:0] cap_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              cmt_we,
  output logic [ADDR_W-1:0] cmt_addr,
  output logic [NBYTES-1:0] cmt_be,
  output logic [DATA_W-1:0] cmt_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              pend_valid,
  output logic [ADDR_W-1:0] pend_addr
);
  logic              pv_q, pv_d;
  logic [ADDR_W-1:0] pa_q, pa_d;
  logic [NBYTES-1:0] pbe_q, pbe_d;
  logic [DATA_W-1:0] pd_q, pd_d;
  logic              hit;

  always_comb begin
    pv_d  = pv_q;
    pa_d  = pa_q;
    pbe_d = pbe_q;
    pd_d  = pd_q;
    if (cap) begin
      pv_d  = 1'b1;
      pa_d  = cap_addr;
      pbe_d = cap_be;
      pd_d  = cap_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q  <= 1'b0;
      pa_q  <= '0;
      pbe_q <= '0;
    end else if (clk_en) begin
      pv_q  <= pv_d;
      pa_q  <= pa_d;
      pbe_q <= pbe_d;
    end
  end

  always_ff @(posedge clk) begin
    if (clk_en) pd_q <= pd_d;
  end

  // The held word goes to the array when the next write's data displaces it.
  assign cmt_we   = clk_en && cap && pv_q;
  assign cmt_addr = pa_q;
  assign cmt_be   = pbe_q;
  assign cmt_data = pd_q;

  assign hit = pv_q && (pa_q == rd_addr);

  for (genvar b = 0; b < NBYTES; b++) begin : g_fwd
    assign rd_data[b*BYTE_W +: BYTE_W] = (hit && pbe_q[b]) ? pd_q[b*BYTE_W +: BYTE_W]
                                                           : arr_rdata[b*BYTE_W +: BYTE_W];
  end

  assign pend_valid = pv_q;
  assign pend_addr  = pa_q;
endmodule

// File: rtl/fts_array.sv
`timescale 1ns/1ps
module fts_array #(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 2,
  localparam int DATA_W = BYTE_W * NBYTES,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [NBYTES-1:0] wbe,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] lane [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wbe[b]) lane[waddr] <= wdata[b*BYTE_W +: BYTE_W];
    end

    assign rdata[b*BYTE_W +: BYTE_W] = lane[raddr];
  end
endmodule

// File: rtl/flowthru_sram.sv
`timescale 1ns/1ps
module flowthru_sram #(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 2,
  localparam int DATA_W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              load_new,
  input  logic              wr_en,
  input  logic [NBYTES-1:0] byte_wr,
  input  logic              chip_sel_n0,
  input  logic              chip_sel1,
  input  logic              chip_sel_n2,
  input  logic              out_en,
  input  logic              seq_mode,
  inout  wire  [DATA_W-1:0] dq
);
  logic              rst_q_n;
  logic              sel_ok;
  logic              cur_valid, cur_write;
  logic [ADDR_W-1:0] cur_addr;
  logic [NBYTES-1:0] cur_be;
  logic              cmt_we;
  logic [ADDR_W-1:0] cmt_addr;
  logic [NBYTES-1:0] cmt_be;
  logic [DATA_W-1:0] cmt_data, arr_rdata, rd_data;
  logic              pend_valid;
  logic [ADDR_W-1:0] pend_addr;
  logic              drv_on;

  assign sel_ok = !chip_sel_n0 && chip_sel1 && !chip_sel_n2;

  fts_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  fts_addr_seq #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_seq (
    .clk(clk), .rst_n(rst_q_n), .clk_en(clk_en), .load_new(load_new),
    .wr_en(wr_en), .sel_ok(sel_ok), .seq_mode(seq_mode), .byte_wr(byte_wr),
    .addr(addr), .cur_valid(cur_valid), .cur_write(cur_write),
    .cur_addr(cur_addr), .cur_be(cur_be)
  );

  fts_wr_buf #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_wbuf (
    .clk(clk), .rst_n(rst_q_n), .clk_en(clk_en),
    .cap(cur_valid && cur_write), .cap_addr(cur_addr), .cap_be(cur_be),
    .cap_data(dq), .rd_addr(cur_addr), .arr_rdata(arr_rdata),
    .cmt_we(cmt_we), .cmt_addr(cmt_addr), .cmt_be(cmt_be), .cmt_data(cmt_data),
    .rd_data(rd_data), .pend_valid(pend_valid), .pend_addr(pend_addr)
  );

  fts_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_arr (
    .clk(clk), .we(cmt_we), .waddr(cmt_addr), .wbe(cmt_be), .wdata(cmt_data),
    .raddr(cur_addr), .rdata(arr_rdata)
  );

  // Drivers are on only in a read data phase; out_en gates them without a clock.
  assign drv_on = out_en && cur_valid && !cur_write;
  assign dq     = drv_on ? rd_data : {DATA_W{1'bz}};
endmodule

// File: rtl/flowthru_sram_chk.sv
`timescale 1ns/1ps
module flowthru_sram_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              load_new,
  input logic              wr_en,
  input logic              sel_ok,
  input logic              drv_on,
  input logic              cur_valid,
  input logic              cur_write,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              pend_valid,
  input logic [ADDR_W-1:0] pend_addr
);
  p_write_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && cur_valid && cur_write) |=> (pend_valid && pend_addr == $past(cur_addr)));

  p_deselect_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && load_new && !sel_ok) |=> !drv_on);

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(cur_addr) && $stable(cur_valid) && $stable(cur_write)
                 && $stable(pend_valid) && $stable(pend_addr)));

  p_write_phase_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && load_new && sel_ok && wr_en) |=> !drv_on);

  p_burst_group_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !load_new) |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

  p_advance_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !load_new) |=> (cur_valid == $past(cur_valid) && cur_write == $past(cur_write)));
endmodule

bind flowthru_sram flowthru_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .clk_en(clk_en), .load_new(load_new), .wr_en(wr_en),
  .sel_ok(sel_ok), .drv_on(drv_on), .cur_valid(cur_valid), .cur_write(cur_write),
  .cur_addr(cur_addr), .pend_valid(pend_valid), .pend_addr(pend_addr)
);

// File: tb/flowthru_sram_bench.sv
`timescale 1ns/1ps
module flowthru_sram_bench;
  localparam int AW = 10;
  localparam int DW = 18;
  localparam logic [2:0] CS_ON = 3'b010;  // {chip_sel_n0, chip_sel1, chip_sel_n2}

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          clk_en, load_new, wr_en, seq_mode, out_en, cs_n0, cs1, cs_n2;
  logic [1:0]    byte_wr;
  logic [AW-1:0] addr;
  logic          tb_drv;
  logic [DW-1:0] tb_data;
  wire  [DW-1:0] dq;

  assign dq = tb_drv ? tb_data : {DW{1'bz}};

  flowthru_sram #(.ADDR_W(AW)) u_flowthru_sram (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .addr(addr), .load_new(load_new),
    .wr_en(wr_en), .byte_wr(byte_wr), .chip_sel_n0(cs_n0), .chip_sel1(cs1),
    .chip_sel_n2(cs_n2), .out_en(out_en), .seq_mode(seq_mode), .dq(dq)
  );

  int checks = 0;
  int errors = 0;

  // Reference model: a 32-word window and the access in its data phase.
  logic [DW-1:0] mem [0:31];
  logic          ph_valid = 1'b0, ph_write = 1'b0, b_ord = 1'b0;
  logic [AW-1:0] ph_addr = '0, b_base = '0;
  logic [1:0]    ph_be = '0, b_cnt = '0;

  function automatic logic [AW-1:0] burst_addr(input logic [AW-1:0] base, input logic [1:0] k,
                                               input logic ord);
    logic [1:0] o;
    o = ord ? (base[1:0] ^ k) : (base[1:0] + k);
    return {base[AW-1:2], o};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: apply inputs at the falling edge, update the model at the rising edge,
  // then check the bus at the next falling edge.
  task automatic step(input bit ce, input bit ld, input bit we, input logic [1:0] be,
                      input logic [AW-1:0] a, input logic [2:0] cs, input bit md,
                      input bit oe, input string tag);
    bit exp_dev;
    clk_en = ce; load_new = ld; wr_en = we; byte_wr = be; addr = a;
    {cs_n0, cs1, cs_n2} = cs; seq_mode = md; out_en = oe;
    @(posedge clk);
    if (ce) begin
      if (ph_valid && ph_write) begin
        if (ph_be[0]) mem[ph_addr[4:0]][8:0]  = tb_data[8:0];
        if (ph_be[1]) mem[ph_addr[4:0]][17:9] = tb_data[17:9];
      end
      if (ld) begin
        ph_valid = (cs == CS_ON); ph_write = we; ph_addr = a;
        b_base = a; b_cnt = 2'd0; b_ord = md;
      end else begin
        b_cnt = b_cnt + 2'd1;
        ph_addr = burst_addr(b_base, b_cnt, b_ord);
      end
      ph_be = be;
    end
    #1;
    exp_dev = ph_valid && !ph_write && oe;
    if (ce || (tb_drv == exp_dev)) begin
      tb_drv  = !exp_dev;
      tb_data = (ph_valid && ph_write) ? (DW'($urandom) | 18'h1) : '0;
    end
    @(negedge clk);
    if (exp_dev) chk(dq == mem[ph_addr[4:0]], tag, dq, mem[ph_addr[4:0]]);
    else         chk(dq == tb_data, tag, dq, tb_data);
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 1'b0, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    clk_en = 1'b1; load_new = 1'b1; wr_en = 1'b0; byte_wr = '0; addr = '0;
    {cs_n0, cs1, cs_n2} = 3'b111; seq_mode = 1'b0; out_en = 1'b1;
    tb_drv = 1'b1; tb_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(dq == '0, "R1 idle after reset", dq, '0);
    step(1, 1, 0, 2'b00, 10'd0, 3'b111, 0, 1, "R1 deselect after reset");

    // R3: full-word writes fill the window, back to back.
    for (int i = 0; i < 32; i++) step(1, 1, 1, 2'b11, AW'(i), CS_ON, 0, 1, "R3 fill");
    // R2: flow-through reads of every word.
    for (int i = 0; i < 32; i++) step(1, 1, 0, 2'b00, AW'(i), CS_ON, 0, 1, "R2 read");

    // R7 / R3: write then immediate read, full and partial bytes, forwarded from the buffer.
    step(1, 1, 1, 2'b11, 10'd3, CS_ON, 0, 1, "R7 wr");
    step(1, 1, 0, 2'b00, 10'd3, CS_ON, 0, 1, "R7 raw full");
    step(1, 1, 1, 2'b01, 10'd3, CS_ON, 0, 1, "R3 wr low byte");
    step(1, 1, 0, 2'b00, 10'd3, CS_ON, 0, 1, "R3 raw low byte");
    step(1, 1, 1, 2'b10, 10'd3, CS_ON, 0, 1, "R3 wr high byte");
    step(1, 1, 0, 2'b00, 10'd3, CS_ON, 0, 1, "R3 raw high byte");
    step(1, 1, 1, 2'b00, 10'd3, CS_ON, 0, 1, "R3 wr no byte");
    step(1, 1, 0, 2'b00, 10'd3, CS_ON, 0, 1, "R3 no byte change");
    step(1, 1, 1, 2'b11, 10'd20, CS_ON, 0, 1, "R7 displace");
    step(1, 1, 0, 2'b00, 10'd3, CS_ON, 0, 1, "R7 array path");
    step(1, 1, 0, 2'b00, 10'd20, CS_ON, 0, 1, "R7 raw next");

    // R4: each chip select alone inactive.
    step(1, 1, 0, 2'b00, 10'd4, 3'b110, 0, 1, "R4 sel0 off read");
    step(1, 1, 1, 2'b11, 10'd4, 3'b000, 0, 1, "R4 sel1 off write");
    step(1, 1, 1, 2'b11, 10'd4, 3'b011, 0, 1, "R4 sel2 off write");
    step(1, 1, 0, 2'b00, 10'd4, CS_ON, 0, 1, "R4 word unchanged");

    // R5: stall in a write data phase, then in a read data phase.
    step(1, 1, 1, 2'b11, 10'd9, CS_ON, 0, 1, "R5 wr");
    step(0, 1, 0, 2'b00, 10'd1, CS_ON, 1, 1, "R5 stall wr");
    step(0, 0, 1, 2'b01, 10'd2, CS_ON, 0, 1, "R5 stall wr");
    step(1, 1, 0, 2'b00, 10'd9, CS_ON, 0, 1, "R5 read after stall");
    step(0, 1, 1, 2'b11, 10'd7, CS_ON, 0, 1, "R5 read held");
    step(0, 1, 1, 2'b11, 10'd8, 3'b111, 0, 1, "R5 read held");
    step(1, 1, 0, 2'b00, 10'd7, CS_ON, 0, 1, "R5 nothing written");

    // R6: out_en low during a read, and asynchronous release mid-cycle.
    step(1, 1, 0, 2'b00, 10'd11, CS_ON, 0, 0, "R6 oe low");
    step(1, 1, 0, 2'b00, 10'd11, CS_ON, 0, 1, "R6 oe high");
    out_en = 1'b0;
    #0.5;
    chk(dq == tb_data, "R6 async release", dq, tb_data);
    tb_drv = 1'b1; tb_data = '0;
    #0.5;
    chk(dq == '0, "R6 async release", dq, '0);
    out_en = 1'b1;
    step(1, 1, 1, 2'b11, 10'd12, CS_ON, 0, 1, "R6 write phase quiet oe high");

    // R8: linear bursts (read, then write burst ignoring wr_en on advances).
    step(1, 1, 0, 2'b00, 10'd5, CS_ON, 0, 1, "R8 lin read");
    for (int k = 1; k < 4; k++) step(1, 0, 1, 2'b00, 10'd0, 3'b111, 1, 1, "R8 lin adv");
    step(1, 1, 1, 2'b11, 10'd14, CS_ON, 0, 1, "R8 lin wr");
    for (int k = 1; k < 4; k++) step(1, 0, 0, 2'b11, 10'd0, 3'b111, 1, 1, "R8 lin wr adv");
    for (int i = 12; i < 16; i++) step(1, 1, 0, 2'b00, AW'(i), CS_ON, 0, 1, "R8 readback");

    // R9: interleaved bursts.
    step(1, 1, 0, 2'b00, 10'd6, CS_ON, 1, 1, "R9 ilv read");
    for (int k = 1; k < 4; k++) step(1, 0, 1, 2'b11, 10'd0, 3'b111, 0, 1, "R9 ilv adv");
    step(1, 1, 1, 2'b11, 10'd25, CS_ON, 1, 1, "R9 ilv wr");
    for (int k = 1; k < 4; k++) step(1, 0, 0, 2'b11, 10'd0, 3'b111, 0, 1, "R9 ilv wr adv");
    for (int i = 24; i < 28; i++) step(1, 1, 0, 2'b00, AW'(i), CS_ON, 0, 1, "R9 readback");

    // R10: advance after a deselect stays deselected even with wr_en and selects active.
    step(1, 1, 1, 2'b11, 10'd17, 3'b110, 0, 1, "R10 deselect");
    for (int k = 1; k < 4; k++) step(1, 0, 1, 2'b11, 10'd0, CS_ON, 0, 1, "R10 adv idle");
    for (int i = 16; i < 20; i++) step(1, 1, 0, 2'b00, AW'(i), CS_ON, 0, 1, "R10 unchanged");

    // R7: random mix of reads, writes, bursts, stalls and deselects.
    for (int n = 0; n < 4000; n++) begin
      bit rce, rld, rwe, rmd, roe;
      logic [2:0] rcs;
      rce = ($urandom % 10) != 0;
      rld = ($urandom % 4) != 0;
      rwe = $urandom % 2;
      rmd = $urandom % 2;
      roe = ($urandom % 20) != 0;
      rcs = (($urandom % 10) == 0) ? 3'($urandom) : CS_ON;
      step(rce, rld, rwe, 2'($urandom), AW'($urandom % 32), rcs, rmd, roe, "R7 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule